// File: doc/BRIEF.md
# Three-Slot LED Pixel Serial Encoder

This block drives one data line in the pulse code that chained smart RGB LEDs expect. Every payload bit becomes a three-slot symbol. A one is high-high-low and a zero is high-low-low, so each 8-bit colour value turns into 24 slots, or three serial bytes. Pixel colours sit in a small register frame memory, which is filled through an address/data write port that takes a green, a red and a blue byte for each pixel.

A one-cycle start strobe sends the whole frame as one unbroken slot stream. Pixels go out in ascending index order. Each pixel sends green, then red, then blue, and every colour goes most significant bit first. The slot period is the clock divided by a power of two. After the last slot the line stays low for a programmable number of slot periods, which forms the latch gap. Then a one-cycle done pulse ends the frame. Issuing start again at any point abandons the current frame and begins over from pixel 0.

Top module: `ledpix_serial_tx`

## Requirements
- R1: After reset, `sdo`, `busy` and `done` are all low.
- R2: Each payload bit is sent as three consecutive slots. A 1 is sent as 1,1,0 and a 0 as 1,0,0. No other slot triple appears.
- R3: A colour byte of 0x00 produces the serial bytes 0x92, 0x49, 0x24 in that order, reading each serial byte's slots from bit 7 down to bit 0.
- R4: Colour bits are sent bit 7 first and bit 0 last.
- R5: Each pixel sends green, red, blue. Pixels go out from index 0 to NUM_PIX-1 with no gap, for 72·NUM_PIX slots in total.
- R6: A slot lasts 2^`div_sel` clock cycles, and `div_sel`=5 gives 32 cycles. `div_sel` and `gap_slots` are captured at start, so later changes do not affect the running frame.
- R7: A start while `busy` is high abandons the current frame and restarts from the green byte of pixel 0. `busy` does not drop in between.
- R8: After the last slot, `sdo` stays low for exactly `gap_slots` slot periods. Then `done` is high for one cycle, in the same cycle that `busy` first reads low. With `gap_slots`=0, `done` follows the last slot directly.
- R9: `busy` is high from the cycle after start until done. Whenever `busy` is low, `sdo` is low.
- R10: A write with `wr_en` high stores `wr_grn`, `wr_red` and `wr_blu` for pixel `wr_addr`. The next frame uses those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Pixel write enable |
| wr_addr | input | AW | Pixel index to write |
| wr_grn | input | 8 | Green value to store |
| wr_red | input | 8 | Red value to store |
| wr_blu | input | 8 | Blue value to store |
| start | input | 1 | One-cycle frame launch or restart |
| div_sel | input | DIV_SEL_W | Slot period is 2^div_sel clocks |
| gap_slots | input | GAP_W | Latch gap length in slot periods |
| sdo | output | 1 | Serial LED data line |
| busy | output | 1 | Frame or latch gap in progress |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
An all-zero frame fixes the idle symbol pattern and the exact serial byte values. A frame with one bit lit at each end of a byte (0x80, 0x01, 0xA5) separates MSB-first order from LSB-first order and shows whether the green, red and blue bytes are swapped. Distinct per-pixel values with alternating 0xFF/0x00 colours reveal pixel order or address errors.

Frames run at divide settings 1, 4, 32 and 2, with gaps of 0, 2, 3 and 4 slots, to separate slot-length and gap-count errors. Changing the settings after launch shows that they are captured at start. A start issued in mid-frame, with new pixel data, shows whether the restart begins from pixel 0 or continues from where the old frame stopped.

// File: rtl/ledpix_pkg.sv
package ledpix_pkg;

  localparam int BYTE_SLOTS = 24;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } tx_state_e;

  // Three slots per bit: lead high, data, trailing low; bit 7 first.
  function automatic logic [BYTE_SLOTS-1:0] expand_byte(input logic [7:0] val);
    logic [BYTE_SLOTS-1:0] pat;
    for (int i = 0; i < 8; i++) begin
      pat[BYTE_SLOTS-1-3*i] = 1'b1;
      pat[BYTE_SLOTS-2-3*i] = val[7-i];
      pat[BYTE_SLOTS-3-3*i] = 1'b0;
    end
    return pat;
  endfunction

endpackage

// File: rtl/ledpix_frame_mem.sv
module ledpix_frame_mem #(
  parameter int NUM_PIX = 8,
  parameter int AW      = 3
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_grn,
  input  logic [7:0]    wr_red,
  input  logic [7:0]    wr_blu,
  input  logic [AW-1:0] rd_pix,
  input  logic [1:0]    rd_col,
  output logic [7:0]    rd_byte
);

  logic [7:0] grn_q [NUM_PIX];
  logic [7:0] red_q [NUM_PIX];
  logic [7:0] blu_q [NUM_PIX];

  for (genvar p = 0; p < NUM_PIX; p++) begin : g_pix
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(p));
    always_ff @(posedge clk) begin
      if (hit) begin
        grn_q[p] <= wr_grn;
        red_q[p] <= wr_red;
        blu_q[p] <= wr_blu;
      end
    end
  end

  always_comb begin
    case (rd_col)
      2'd0:    rd_byte = grn_q[rd_pix];
      2'd1:    rd_byte = red_q[rd_pix];
      default: rd_byte = blu_q[rd_pix];
    endcase
  end

endmodule

// File: rtl/ledpix_slot_timer.sv
module ledpix_slot_timer #(
  parameter int DIV_SEL_W = 3,
  localparam int CW = (1 << DIV_SEL_W) - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 clear,
  input  logic [DIV_SEL_W-1:0] div_sel,
  output logic                 tick
);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW:0]   span;
  logic [CW:0]   last_cnt;

  always_comb begin
    span     = (CW+1)'(1) << div_sel;
    last_cnt = span - (CW+1)'(1);
    tick     = run && !clear && ({1'b0, cnt_q} == last_cnt);
    if (clear || !run || tick) cnt_n = '0;
    else                       cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/ledpix_symbol_shift.sv
module ledpix_symbol_shift
  import ledpix_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       shift_en,
  output logic       slot_bit,
  output logic       last_slot
);

  logic [BYTE_SLOTS-1:0] shreg_q, shreg_n;
  logic [4:0]            pos_q, pos_n;

  always_comb begin
    shreg_n = shreg_q;
    pos_n   = pos_q;
    if (load) begin
      shreg_n = expand_byte(load_byte);
      pos_n   = '0;
    end else if (shift_en) begin
      shreg_n = {shreg_q[BYTE_SLOTS-2:0], 1'b0};
      pos_n   = pos_q + 5'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      pos_q   <= '0;
    end else begin
      shreg_q <= shreg_n;
      pos_q   <= pos_n;
    end
  end

  assign slot_bit  = shreg_q[BYTE_SLOTS-1];
  assign last_slot = (pos_q == 5'(BYTE_SLOTS-1));

endmodule

// File: rtl/ledpix_serial_tx.sv
module ledpix_serial_tx
  import ledpix_pkg::*;
#(
  parameter int NUM_PIX   = 8,
  parameter int DIV_SEL_W = 3,
  parameter int GAP_W     = 16,
  localparam int AW = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [7:0]           wr_grn,
  input  logic [7:0]           wr_red,
  input  logic [7:0]           wr_blu,
  input  logic                 start,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic [GAP_W-1:0]     gap_slots,
  output logic                 sdo,
  output logic                 busy,
  output logic                 done
);

  localparam logic [AW-1:0] LAST_PIX = AW'(NUM_PIX - 1);

  tx_state_e            state_q, state_n;
  logic [AW-1:0]        pix_q, pix_n;
  logic [1:0]           col_q, col_n;
  logic [GAP_W-1:0]     gcnt_q, gcnt_n;
  logic [GAP_W-1:0]     gap_q;
  logic [DIV_SEL_W-1:0] div_q;
  logic                 done_q, done_n;

  logic          slot_tick, slot_bit, last_slot;
  logic          load_en, shift_en, frame_last, running;
  logic [AW-1:0] rd_pix;
  logic [1:0]    rd_col;
  logic [7:0]    rd_byte;

  ledpix_frame_mem #(.NUM_PIX(NUM_PIX), .AW(AW)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_grn(wr_grn), .wr_red(wr_red), .wr_blu(wr_blu),
    .rd_pix(rd_pix), .rd_col(rd_col), .rd_byte(rd_byte)
  );

  ledpix_slot_timer #(.DIV_SEL_W(DIV_SEL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(running), .clear(start),
    .div_sel(div_q), .tick(slot_tick)
  );

  ledpix_symbol_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_en), .load_byte(rd_byte),
    .shift_en(shift_en), .slot_bit(slot_bit), .last_slot(last_slot)
  );

  assign running = (state_q != ST_IDLE);

  // Next colour byte to load: green, red, blue, then the next pixel.
  always_comb begin
    if (start) begin
      rd_pix = '0;
      rd_col = 2'd0;
    end else if (col_q == 2'd2) begin
      rd_pix = pix_q + AW'(1);
      rd_col = 2'd0;
    end else begin
      rd_pix = pix_q;
      rd_col = col_q + 2'd1;
    end
  end

  always_comb begin
    frame_last = last_slot && (col_q == 2'd2) && (pix_q == LAST_PIX);
    state_n    = state_q;
    pix_n      = pix_q;
    col_n      = col_q;
    gcnt_n     = gcnt_q;
    done_n     = 1'b0;
    load_en    = 1'b0;
    shift_en   = 1'b0;
    if (start) begin
      state_n = ST_SEND;
      pix_n   = '0;
      col_n   = 2'd0;
      gcnt_n  = '0;
      load_en = 1'b1;
    end else begin
      case (state_q)
        ST_SEND: begin
          if (slot_tick) begin
            if (!last_slot) begin
              shift_en = 1'b1;
            end else if (!frame_last) begin
              load_en = 1'b1;
              pix_n   = rd_pix;
              col_n   = rd_col;
            end else if (gap_q == '0) begin
              state_n = ST_IDLE;
              done_n  = 1'b1;
            end else begin
              state_n = ST_GAP;
              gcnt_n  = '0;
            end
          end
        end
        ST_GAP: begin
          if (slot_tick) begin
            if (gcnt_q == gap_q - GAP_W'(1)) begin
              state_n = ST_IDLE;
              done_n  = 1'b1;
            end else begin
              gcnt_n = gcnt_q + GAP_W'(1);
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pix_q   <= '0;
      col_q   <= '0;
      gcnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      pix_q   <= pix_n;
      col_q   <= col_n;
      gcnt_q  <= gcnt_n;
      done_q  <= done_n;
    end
  end

  // Settings captured once per frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      gap_q <= '0;
    end else if (start) begin
      div_q <= div_sel;
      gap_q <= gap_slots;
    end
  end

  assign busy = running;
  assign done = done_q;
  assign sdo  = (state_q == ST_SEND) && slot_bit;

endmodule

// File: rtl/ledpix_serial_tx_chk.sv
module ledpix_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic sdo,
  input logic slot_tick
);

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdo);

  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_slot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !slot_tick && !start) |=> $stable(sdo));

endmodule

bind ledpix_serial_tx ledpix_serial_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .sdo(sdo), .slot_tick(slot_tick)
);

// File: tb/tb_ledpix_serial_tx.sv
module tb_ledpix_serial_tx;

  localparam int NP = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n, wr_en, start;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_grn, wr_red, wr_blu;
  logic [2:0] div_sel;
  logic [15:0] gap_slots;
  logic sdo, busy, done;

  always #4 clk = ~clk;

  ledpix_serial_tx #(.NUM_PIX(NP), .DIV_SEL_W(3), .GAP_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_grn(wr_grn), .wr_red(wr_red), .wr_blu(wr_blu), .start(start),
    .div_sel(div_sel), .gap_slots(gap_slots), .sdo(sdo), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit exp_q[$];
  logic [7:0] pg[NP], pr[NP], pb[NP];
  logic slot_log[NP*72];
  int cur_div, cur_gap;
  event go;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_pix(int i, logic [7:0] g, logic [7:0] r, logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(i); wr_grn = g; wr_red = r; wr_blu = b;
    @(negedge clk);
    wr_en = 1'b0;
    pg[i] = g; pr[i] = r; pb[i] = b;
  endtask

  // Driver: expected bits, green-red-blue per pixel, bit 7 first (R4, R5).
  task automatic push_frame;
    exp_q.delete();
    for (int p = 0; p < NP; p++) begin
      for (int k = 7; k >= 0; k--) exp_q.push_back(pg[p][k]);
      for (int k = 7; k >= 0; k--) exp_q.push_back(pr[p][k]);
      for (int k = 7; k >= 0; k--) exp_q.push_back(pb[p][k]);
    end
  endtask

  task automatic pulse_start(int dv, int gp);
    div_sel = 3'(dv); gap_slots = 16'(gp);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic launch(int dv, int gp);
    pulse_start(dv, gp);
    cur_div = dv; cur_gap = gp;
    ->go;
    // R6: later setting changes must not touch the running frame.
    div_sel = 3'd7; gap_slots = 16'd999;
  endtask

  // Monitor: decodes three-slot symbols and pops the scoreboard.
  task automatic monitor_frame;
    int dv, n;
    logic a, b, c;
    bit e;
    @(go);
    dv = 1 << cur_div;
    for (int s = 0; s < NP*24; s++) begin
      a = sdo; repeat (dv) @(negedge clk);
      b = sdo; repeat (dv) @(negedge clk);
      c = sdo; repeat (dv) @(negedge clk);
      slot_log[3*s] = a; slot_log[3*s+1] = b; slot_log[3*s+2] = c;
      chk(a == 1'b1 && c == 1'b0, "R2", "symbol frame", int'({a,b,c}), int'({1'b1,b,1'b0}));
      e = exp_q.pop_front();
      chk(b == e, "R5", $sformatf("data bit %0d", s), int'(b), int'(e));
    end
    n = 0;
    while (!done && n < 70000) begin
      if (sdo) chk(1'b0, "R8", "line low in gap", 1, 0);
      n++;
      @(negedge clk);
    end
    chk(n == cur_gap*dv, "R8", "gap cycles", n, cur_gap*dv);
    chk(busy == 1'b0, "R8", "busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done single cycle", int'(done), 0);
  endtask

  task automatic run_frame(int dv, int gp);
    push_frame();
    fork
      launch(dv, gp);
      monitor_frame();
    join
  endtask

  function automatic logic [7:0] log_byte(int idx);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[7-i] = slot_log[8*idx+i];
    return v;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; start = 1'b0; wr_addr = '0;
    wr_grn = '0; wr_red = '0; wr_blu = '0; div_sel = '0; gap_slots = '0;
    repeat (3) @(negedge clk);
    chk(sdo == 0 && busy == 0 && done == 0, "R1", "reset outputs",
        int'({sdo, busy, done}), 0);
    rst_n = 1'b1;

    // R3: all-zero frame, divide by 1, gap 4.
    for (int i = 0; i < NP; i++) write_pix(i, 8'h00, 8'h00, 8'h00);
    run_frame(0, 4);
    chk(log_byte(0) == 8'h92, "R3", "serial byte 0", int'(log_byte(0)), 8'h92);
    chk(log_byte(1) == 8'h49, "R3", "serial byte 1", int'(log_byte(1)), 8'h49);
    chk(log_byte(2) == 8'h24, "R3", "serial byte 2", int'(log_byte(2)), 8'h24);

    // R4, R10, R6: distinct pixels, divide by 32, gap 2.
    write_pix(0, 8'h80, 8'h01, 8'hA5);
    for (int i = 1; i < NP; i++) write_pix(i, 8'(i*37+5), 8'(i*91+3), 8'(255-i*19));
    run_frame(5, 2);
    chk({slot_log[0], slot_log[1], slot_log[2]} == 3'b110, "R4", "msb symbol",
        int'({slot_log[0], slot_log[1], slot_log[2]}), 6);
    chk({slot_log[3], slot_log[4], slot_log[5]} == 3'b100, "R4", "second symbol",
        int'({slot_log[3], slot_log[4], slot_log[5]}), 4);
    chk({slot_log[45], slot_log[46], slot_log[47]} == 3'b110, "R4", "red lsb symbol",
        int'({slot_log[45], slot_log[46], slot_log[47]}), 6);

    // R8: alternating colours, divide by 4, zero gap.
    for (int i = 0; i < NP; i++) write_pix(i, (i % 2) ? 8'hFF : 8'h00, 8'h5A, (i % 2) ? 8'h00 : 8'hFF);
    run_frame(2, 0);

    // R9: idle line stays low.
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (sdo || busy) quiet = 1'b0;
      end
      chk(quiet, "R9", "idle line and busy low", int'(quiet), 1);
    end

    // R7: restart mid-frame with new data.
    pulse_start(1, 3);
    repeat (200) @(negedge clk);
    chk(busy == 1'b1, "R7", "busy mid-frame", int'(busy), 1);
    for (int i = 0; i < NP; i++) write_pix(i, 8'(8'hC3 ^ i), 8'(i), 8'(8'h3C + i));
    chk(busy == 1'b1, "R7", "busy before restart", int'(busy), 1);
    run_frame(1, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule